// File: doc/BRIEF.md
# Lazy Loop Range Task Expander

This block holds compact descriptors for parallel loops. Each descriptor carries two opaque words, an iteration count N and a chunk size S. The block turns a descriptor into sub-range tasks only when a consumer asks for one. Storing a descriptor costs one slot however many tasks it stands for. Each task handed out carries the two opaque words unchanged, plus a begin index and an end index. Successive tasks from one descriptor cover the range 0..N in consecutive chunks of S iterations.

A producer writes descriptors through a valid/ready push port. A scheduler takes tasks through a valid/ready pop port. It can read a count of the tasks still to be handed out across all stored descriptors. Descriptors are served strictly in push order. A descriptor is retired once its final chunk has been taken. A descriptor with N or S equal to zero is accepted and then dropped, so it yields no task.

Top module: `lre_expander`

## Requirements
- R1: push_ready_o is high exactly when fewer than DEPTH expandable descriptors are stored. Each stored descriptor takes one slot, whatever its task count.
- R2: A descriptor with N = 0 or S = 0 is accepted on push and produces no task. It changes neither task_valid_o nor task_cnt_o.
- R3: Every task presents the v1 and v2 words of its descriptor unchanged.
- R4: The first task of a descriptor begins at 0. The end index is exclusive, and each later task begins at the end index of the task before it. An offered task holds steady until it is taken.
- R5: Each task spans S iterations, except the final one. The final task ends at N and is shorter than S when N is not a multiple of S.
- R6: A descriptor yields ceil(N/S) tasks and then retires. Tasks of the next descriptor, in push order, follow directly.
- R7: task_cnt_o equals the sum, over stored descriptors, of ceil(unissued iterations / S). It updates on the cycle after a push or pop handshake, and it is nonzero exactly when task_valid_o is high.
- R8: After reset no task is offered, task_cnt_o is 0 and push_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Descriptor offered |
| push_ready_o | output | 1 | Descriptor slot free |
| push_v1_i | input | DW | First opaque word |
| push_v2_i | input | DW | Second opaque word |
| push_n_i | input | W | Iteration count N |
| push_s_i | input | W | Chunk size S |
| task_valid_o | output | 1 | Task available |
| task_ready_i | input | 1 | Consumer takes the task |
| task_v1_o | output | DW | First opaque word of task |
| task_v2_o | output | DW | Second opaque word of task |
| task_beg_o | output | W | First iteration of task |
| task_end_o | output | W | Iteration after the last of task (exclusive) |
| task_cnt_o | output | W+clog2(DEPTH)+1 | Tasks still to be issued |

## Verification
The assertions assume a producer that offers descriptors with push_valid_i and never writes into a full store without push_ready_o. They also assume that the head descriptor held inside the block has nonzero N and S, because zero descriptors are filtered before storage. The bench drives push_valid_i only after it has seen push_ready_o high, and it asserts task_ready_i only while a task is offered. It sweeps every N and S of a 4-bit configuration, including the zero values, and then fills the store to capacity to exercise back-pressure and ordering.

// File: rtl/lre_desc_fifo.sv
module lre_desc_fifo #(
  parameter int EW    = 48,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [EW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [EW-1:0] rd_data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [FW-1:0] fill_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (fill_q == FW'(DEPTH));
  assign empty_o   = (fill_q == '0);
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= nxt(rd_ptr_q);
      if (wr_en_i && !rd_en_i)      fill_q <= fill_q + 1'b1;
      else if (rd_en_i && !wr_en_i) fill_q <= fill_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_ptr_q == PW'(i)) mem_q[i] <= wr_data_i;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !empty_o); // R6
endmodule

// File: rtl/lre_chunker.sv
module lre_chunker #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         head_valid_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] s_i,
  input  logic         take_i,
  output logic [W-1:0] beg_o,
  output logic [W-1:0] end_o,
  output logic         last_o
);
  logic [W-1:0] cur_q;
  logic [W:0]   end_w;

  assign end_w  = {1'b0, cur_q} + {1'b0, s_i};
  assign last_o = (end_w >= {1'b0, n_i});
  assign end_o  = last_o ? n_i : end_w[W-1:0];
  assign beg_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (take_i) cur_q <= last_o ? '0 : end_w[W-1:0];
  end

  AST_CURSOR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_i |-> (cur_q < n_i)); // R4
  AST_CHUNK_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_i |-> (end_o > beg_o) && ((end_o - beg_o) <= s_i)); // R5
endmodule

// File: rtl/lre_task_count.sv
module lre_task_count #(
  parameter int W  = 16,
  parameter int CW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic [W-1:0]  n_i,
  input  logic [W-1:0]  s_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  logic [W:0]    num_w;
  logic [W:0]    tasks_w;
  logic [CW-1:0] cnt_q;

  assign num_w   = {1'b0, n_i} + {1'b0, s_i} - 1'b1;
  assign tasks_w = (s_i == '0) ? '0 : num_w / {1'b0, s_i};
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_q + (add_i ? CW'(tasks_w) : '0) - (dec_i ? CW'(1) : '0);
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !add_i) |-> (cnt_q != '0)); // R7
endmodule

// File: rtl/lre_expander.sv
module lre_expander #(
  parameter int DW    = 32,
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int EW   = 2 * DW + 2 * W,
  localparam int CW   = W + $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  output logic          push_ready_o,
  input  logic [DW-1:0] push_v1_i,
  input  logic [DW-1:0] push_v2_i,
  input  logic [W-1:0]  push_n_i,
  input  logic [W-1:0]  push_s_i,
  output logic          task_valid_o,
  input  logic          task_ready_i,
  output logic [DW-1:0] task_v1_o,
  output logic [DW-1:0] task_v2_o,
  output logic [W-1:0]  task_beg_o,
  output logic [W-1:0]  task_end_o,
  output logic [CW-1:0] task_cnt_o
);
  logic          full, empty, last, take, keep;
  logic [EW-1:0] head;
  logic [W-1:0]  head_n, head_s;

  // zero-sized descriptors are accepted but never stored
  assign keep = push_valid_i && push_ready_o && (push_n_i != '0) && (push_s_i != '0);
  assign take = task_valid_o && task_ready_i;

  assign push_ready_o = !full;
  assign task_valid_o = !empty;
  assign {task_v1_o, task_v2_o, head_n, head_s} = head;

  lre_desc_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_en_i   (keep),
    .wr_data_i ({push_v1_i, push_v2_i, push_n_i, push_s_i}),
    .rd_en_i   (take && last),
    .rd_data_o (head),
    .full_o    (full),
    .empty_o   (empty)
  );

  lre_chunker #(.W(W)) u_chunk (
    .clk_i, .rst_ni,
    .head_valid_i (task_valid_o),
    .n_i          (head_n),
    .s_i          (head_s),
    .take_i       (take),
    .beg_o        (task_beg_o),
    .end_o        (task_end_o),
    .last_o       (last)
  );

  lre_task_count #(.W(W), .CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .add_i (keep),
    .n_i   (push_n_i),
    .s_i   (push_s_i),
    .dec_i (take),
    .cnt_o (task_cnt_o)
  );

  AST_CNT_TRACKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_cnt_o != '0) == task_valid_o); // R7
  AST_TASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_valid_o && !task_ready_i) |=> task_valid_o && $stable(task_beg_o) && $stable(task_end_o)); // R4
  AST_NO_HEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    task_valid_o |-> (head_n != '0) && (head_s != '0)); // R2
endmodule

// File: tb/lre_expander_test.sv
`timescale 1ns/1ps
module lre_expander_test;
  localparam int DW = 8, W = 4, DEPTH = 2;
  localparam int CW = W + $clog2(DEPTH) + 1;

  logic clk = 0, rst_ni = 0;
  logic push_valid_i = 0, task_ready_i = 0;
  logic [DW-1:0] push_v1_i = '0, push_v2_i = '0;
  logic [W-1:0] push_n_i = '0, push_s_i = '0;
  logic push_ready_o, task_valid_o;
  logic [DW-1:0] task_v1_o, task_v2_o;
  logic [W-1:0] task_beg_o, task_end_o;
  logic [CW-1:0] task_cnt_o;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  lre_expander #(.DW(DW), .W(W), .DEPTH(DEPTH)) uut (.clk_i(clk), .*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int v1, input int v2, input int n, input int s);
    push_valid_i = 1; push_v1_i = DW'(v1); push_v2_i = DW'(v2);
    push_n_i = W'(n); push_s_i = W'(s);
    @(posedge clk); #1 push_valid_i = 0;
    @(negedge clk);
  endtask

  task automatic pop;
    task_ready_i = 1;
    @(posedge clk); #1 task_ready_i = 0;
    @(negedge clk);
  endtask

  task automatic expect_task(input string req, input int v1, input int v2, input int b, input int e);
    chk({req, " valid"}, int'(task_valid_o), 1);
    chk("R3 v1", int'(task_v1_o), v1 & 8'hff);
    chk("R3 v2", int'(task_v2_o), v2 & 8'hff);
    chk("R4 beg", int'(task_beg_o), b);
    chk("R5 end", int'(task_end_o), e);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R8 valid", int'(task_valid_o), 0);
    chk("R8 cnt", int'(task_cnt_o), 0);
    chk("R8 ready", int'(push_ready_o), 1);

    // exhaustive sweep of N and S
    for (int n = 0; n < 16; n++) begin
      for (int s = 0; s < 16; s++) begin
        int nt;
        nt = (n == 0 || s == 0) ? 0 : (n + s - 1) / s;
        chk("R1 ready", int'(push_ready_o), 1);
        push(n * 16 + s, 255 - n, n, s);
        chk("R7 cnt after push", int'(task_cnt_o), nt);
        if (nt == 0) chk("R2 no task", int'(task_valid_o), 0);
        for (int k = 0; k < nt; k++) begin
          int e;
          e = ((k + 1) * s > n) ? n : (k + 1) * s;
          expect_task("R4", n * 16 + s, 255 - n, k * s, e);
          chk("R5 len", int'(task_end_o) - int'(task_beg_o), (e == n) ? n - k * s : s);
          pop;
          chk("R7 cnt after pop", int'(task_cnt_o), nt - k - 1);
        end
        chk("R6 retired", int'(task_valid_o), 0);
      end
    end

    // fill, back-pressure, order
    push(8'h11, 8'h22, 5, 2);
    push(8'h0, 8'h0, 0, 3);
    chk("R2 zero keeps cnt", int'(task_cnt_o), 3);
    chk("R1 slot free", int'(push_ready_o), 1);
    push(8'h33, 8'h44, 7, 7);
    chk("R1 full", int'(push_ready_o), 0);
    chk("R7 cnt total", int'(task_cnt_o), 4);
    expect_task("R6", 8'h11, 8'h22, 0, 2);
    repeat (2) @(negedge clk);
    expect_task("R4 held", 8'h11, 8'h22, 0, 2);
    pop;
    chk("R7 cnt 3", int'(task_cnt_o), 3);
    chk("R1 still full", int'(push_ready_o), 0);
    expect_task("R6", 8'h11, 8'h22, 2, 4);
    pop;
    expect_task("R6", 8'h11, 8'h22, 4, 5);
    pop;
    chk("R1 freed", int'(push_ready_o), 1);
    expect_task("R6 next descriptor", 8'h33, 8'h44, 0, 7);
    pop;
    chk("R6 empty", int'(task_valid_o), 0);
    chk("R7 cnt 0", int'(task_cnt_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule